// File: doc/BRIEF.md
# Input Capture Down-Counter Timer

This block is a free-running 16-bit down-counter that timestamps the edges of an external input. While capture mode is selected, the counter drops by one on every clock. When the chosen edge of the input arrives, the live count is copied into a capture register. Software finds the time between two events by subtracting two captured values. It counts the underflows that fall between them, which the block reports through a separate pending flag.

The input passes through a two-flop synchronizer before edge detection, so capture latency is fixed. A single select bit chooses the rising or the falling edge. It may be flipped while the counter runs, so the same input can be timestamped on both edges and a pulse width can be measured. Leaving capture mode is the only way to stop the counter. While stopped, software can preload a starting count, commonly all ones. Both pending flags drive one interrupt line, gated by a local enable and a global enable.

Top module: `capture_timer`

## Requirements
- R1: While `capture_mode` is 1, `count_val` decreases by exactly one on every rising clock edge, starting at the first edge on which the mode is sampled high.
- R2: An input level change first sampled at clock edge k is detected at edge k+2. If it matches the selected edge, `capture_val` takes the value `count_val` held just before edge k+2, and `cap_pend` becomes 1 after that edge.
- R3: When the counter is 0x0000 in capture mode, the next edge wraps it to 0xFFFF and sets `unf_pend`; counting continues.
- R4: If a capture and an underflow fall on the same edge, `cap_pend` and `unf_pend` both become 1 after that edge, and `capture_val` holds 0x0000.
- R5: `irq` is 1 exactly when (`cap_pend` or `unf_pend`) is 1 and both `tmr_irq_en` and `global_irq_en` are 1.
- R6: `edge_falling` = 0 selects rising edges and 1 selects falling edges. A transition of the other direction leaves `cap_pend` and `capture_val` unchanged. The select may change while the counter runs.
- R7: With `capture_mode` at 0, the counter holds its value, and `preload_we` = 1 loads `preload_val` on the next edge. With `capture_mode` at 1, `preload_we` has no effect on the counter.
- R8: `cap_pend_clr` / `unf_pend_clr` = 1 clears the matching flag on the next edge (write-one-to-clear). A hardware set on the same edge wins, leaving the flag at 1.
- R9: After synchronous reset (`rst_n` low on an edge), `count_val` = 0xFFFF, `capture_val` = 0x0000, both flags are 0 and `irq` is 0.
- R10: An input pulse lasting one clock period is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_in | input | 1 | Asynchronous external input whose edges are timestamped |
| capture_mode | input | 1 | 1 runs the counter in capture mode, 0 stops it |
| edge_falling | input | 1 | Edge select: 0 rising, 1 falling |
| tmr_irq_en | input | 1 | Local interrupt enable |
| global_irq_en | input | 1 | Global interrupt enable |
| preload_we | input | 1 | Load strobe for the counter (honoured only while stopped) |
| preload_val | input | 16 | Value loaded into the counter |
| cap_pend_clr | input | 1 | Write-one-to-clear for the capture flag |
| unf_pend_clr | input | 1 | Write-one-to-clear for the underflow flag |
| count_val | output | 16 | Live counter value |
| capture_val | output | 16 | Last captured counter value |
| cap_pend | output | 1 | Capture pending flag |
| unf_pend | output | 1 | Underflow pending flag |
| irq | output | 1 | Timer interrupt |

## Verification
A wrong counter step appears on `count_val` on the very next clock and shifts every later captured timestamp. A synchronizer stage too many or too few shows as a capture value off by one count and a flag that rises one cycle early or late. A flipped edge select or a lost short pulse leaves `cap_pend` low where it should rise. A clear that beats a simultaneous set drops a flag, and with it the interrupt, in the cycle after the collision. The reference model is compared on every clock, so any of these faults is caught in the cycle it first reaches a port.

// File: rtl/cap_timer_pkg.sv
// Package: shared widths and the edge-select encoding for the capture timer.
// Assumes: nothing; pure type and constant definitions.
package cap_timer_pkg;
    localparam int unsigned DEF_CNT_W       = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/ict_edge_detect.sv
// Synchronizes an asynchronous input through SYNC_STAGES flops and flags the
// selected edge for one cycle. Assumes SYNC_STAGES >= 2; any pulse of at
// least one clock period is sampled by the first stage.
module ict_edge_detect
    import cap_timer_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_async,
    input  edge_sel_e edge_sel,
    input  logic      enable,
    output logic      edge_hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    // Shift the input through the synchronizer chain and keep the last output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            prev_q <= sync_out;
        end
    end

    // Pick the edge direction requested by the select bit.
    always_comb begin
        if (edge_sel == EDGE_FALL) edge_hit = enable & ~sync_out & prev_q;
        else                       edge_hit = enable & sync_out & ~prev_q;
    end
endmodule

// File: rtl/ict_down_counter.sv
// Down-counter that decrements once per clock while running and wraps from
// zero to all ones. Assumes the preload is honoured only while stopped.
module ict_down_counter
    import cap_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = run && (count == '0);

    // Count down while running, otherwise hold or accept a preload.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '1;
        else if (run)     count <= count - 1'b1;
        else if (load_en) count <= load_val;
    end

    // R1
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (count == $past(count) - 1'b1));

    // R3
    wrap_to_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '1));

    // R7
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_en) |=> $stable(count));
endmodule

// File: rtl/ict_pend_flags.sv
// Two independent sticky pending flags with write-one-to-clear. A hardware
// set on the same edge as a clear wins. Assumes set pulses last one cycle.
module ict_pend_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_set,
    input  logic unf_set,
    input  logic cap_clr,
    input  logic unf_clr,
    output logic cap_pend,
    output logic unf_pend
);
    // Update each flag: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pend <= 1'b0;
            unf_pend <= 1'b0;
        end else begin
            cap_pend <= cap_set | (cap_pend & ~cap_clr);
            unf_pend <= unf_set | (unf_pend & ~unf_clr);
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_set && cap_clr) |=> cap_pend);

    // R4
    dual_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_set && unf_set) |=> (cap_pend && unf_pend));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_clr && !unf_set) |=> !unf_pend);
endmodule

// File: rtl/capture_timer.sv
// Top of the input-capture timer: synchronizer and edge detector, free-running
// down-counter, capture register, pending flags and the gated interrupt.
// Assumes tmr_in is asynchronous; all control inputs are synchronous to clk.
module capture_timer
    import cap_timer_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_in,
    input  logic             capture_mode,
    input  logic             edge_falling,
    input  logic             tmr_irq_en,
    input  logic             global_irq_en,
    input  logic             preload_we,
    input  logic [CNT_W-1:0] preload_val,
    input  logic             cap_pend_clr,
    input  logic             unf_pend_clr,
    output logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] capture_val,
    output logic             cap_pend,
    output logic             unf_pend,
    output logic             irq
);
    logic      cap_hit;
    logic      wrap;
    edge_sel_e edge_sel;

    assign edge_sel = edge_falling ? EDGE_FALL : EDGE_RISE;

    ict_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (tmr_in),
        .edge_sel  (edge_sel),
        .enable    (capture_mode),
        .edge_hit  (cap_hit)
    );

    ict_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (capture_mode),
        .load_en  (preload_we),
        .load_val (preload_val),
        .count    (count_val),
        .wrap     (wrap)
    );

    ict_pend_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_set  (cap_hit),
        .unf_set  (wrap),
        .cap_clr  (cap_pend_clr),
        .unf_clr  (unf_pend_clr),
        .cap_pend (cap_pend),
        .unf_pend (unf_pend)
    );

    // Latch the live count when the selected edge is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)       capture_val <= '0;
        else if (cap_hit) capture_val <= count_val;
    end

    // Combine both flags into one interrupt behind the two enables.
    assign irq = (cap_pend | unf_pend) & tmr_irq_en & global_irq_en;

    // R2
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (capture_val == $past(count_val) && cap_pend));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tmr_irq_en && global_irq_en));

    // R6
    no_capture_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_mode && !cap_pend_clr && !cap_pend) |=> !cap_pend);
endmodule

// File: tb/test_capture_timer.sv
module test_capture_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_in = 1'b0;
    logic        capture_mode = 1'b0;
    logic        edge_falling = 1'b0;
    logic        tmr_irq_en = 1'b0;
    logic        global_irq_en = 1'b0;
    logic        preload_we = 1'b0;
    logic [15:0] preload_val = 16'h0;
    logic        cap_pend_clr = 1'b0;
    logic        unf_pend_clr = 1'b0;
    logic [15:0] count_val;
    logic [15:0] capture_val;
    logic        cap_pend;
    logic        unf_pend;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    int   m_cnt = 16'hFFFF;
    int   m_cap = 0;
    bit   m_cp = 1'b0;
    bit   m_up = 1'b0;
    logic m_q[$] = '{1'b0, 1'b0, 1'b0};

    always #10 clk = ~clk;

    capture_timer i_capture_timer (
        .clk(clk), .rst_n(rst_n), .tmr_in(tmr_in), .capture_mode(capture_mode),
        .edge_falling(edge_falling), .tmr_irq_en(tmr_irq_en),
        .global_irq_en(global_irq_en), .preload_we(preload_we),
        .preload_val(preload_val), .cap_pend_clr(cap_pend_clr),
        .unf_pend_clr(unf_pend_clr), .count_val(count_val),
        .capture_val(capture_val), .cap_pend(cap_pend), .unf_pend(unf_pend),
        .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural model: edge seen two samples late, count steps down per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 16'hFFFF; m_cap = 0; m_cp = 0; m_up = 0;
            m_q = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit cap_ev, unf_ev;
            if (edge_falling) cap_ev = capture_mode && m_q[1] == 1'b0 && m_q[0] == 1'b1;
            else              cap_ev = capture_mode && m_q[1] == 1'b1 && m_q[0] == 1'b0;
            unf_ev = capture_mode && m_cnt == 0;
            if (cap_ev) m_cap = m_cnt;
            m_cp = (m_cp && !cap_pend_clr) || cap_ev;
            m_up = (m_up && !unf_pend_clr) || unf_ev;
            if (capture_mode) m_cnt = (m_cnt - 1) & 16'hFFFF;
            else if (preload_we) m_cnt = preload_val;
            m_q.push_back(tmr_in);
            void'(m_q.pop_front());
        end
    end

    // Compare every port against the model, mid-cycle.
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R1 count", count_val, m_cnt);
            chk("R2 capture", capture_val, m_cap);
            chk("R2 cap_pend", cap_pend, m_cp);
            chk("R3 unf_pend", unf_pend, m_up);
            chk("R5 irq", irq, (m_cp || m_up) && tmr_irq_en && global_irq_en);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic clear_caps();
        cap_pend_clr = 1'b1; step(1); cap_pend_clr = 1'b0; step(1);
    endtask

    initial begin
        int hold;
        step(3);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 count", count_val, 16'hFFFF);
        chk("R9 capture", capture_val, 0);
        chk("R9 flags", {cap_pend, unf_pend}, 0);
        chk("R9 irq", irq, 0);
        // R7 preload while stopped
        preload_val = 16'h0040; preload_we = 1'b1; step(1); preload_we = 1'b0; step(2);
        chk("R7 preload", count_val, 16'h0040);
        tmr_irq_en = 1'b1; global_irq_en = 1'b1;
        // R1 run
        capture_mode = 1'b1; step(5);
        chk("R1 decrement", count_val, 16'h0040 - 5);
        // R2 rising capture
        tmr_in = 1'b1; step(4);
        chk("R2 pend", cap_pend, 1);
        chk("R5 irq on", irq, 1);
        clear_caps();
        chk("R8 w1c", cap_pend, 0);
        // R6 opposite edge ignored
        hold = capture_val;
        tmr_in = 1'b0; step(4);
        chk("R6 ignored pend", cap_pend, 0);
        chk("R6 ignored value", capture_val, hold);
        // R6 live switch to falling
        edge_falling = 1'b1;
        tmr_in = 1'b1; step(4);
        chk("R6 rise ignored", cap_pend, 0);
        tmr_in = 1'b0; step(4);
        chk("R6 fall captured", cap_pend, 1);
        clear_caps();
        // R10 one-cycle pulse
        edge_falling = 1'b0;
        tmr_in = 1'b1; step(1); tmr_in = 1'b0; step(4);
        chk("R10 short pulse", cap_pend, 1);
        clear_caps();
        // R8 set and clear on the same edge
        tmr_in = 1'b1; step(2);
        cap_pend_clr = 1'b1; step(1); cap_pend_clr = 1'b0;
        chk("R8 set wins", cap_pend, 1);
        tmr_in = 1'b0; step(1);
        clear_caps();
        // R5 masking
        tmr_in = 1'b1; step(4);
        global_irq_en = 1'b0; step(1);
        chk("R5 global mask", irq, 0);
        global_irq_en = 1'b1; tmr_irq_en = 1'b0; step(1);
        chk("R5 local mask", irq, 0);
        tmr_irq_en = 1'b1;
        tmr_in = 1'b0; step(1);
        clear_caps();
        // R4 capture and underflow on the same edge
        capture_mode = 1'b0; preload_val = 16'h0008; preload_we = 1'b1; step(1);
        preload_we = 1'b0; capture_mode = 1'b1;
        while (count_val != 16'h0002) step(1);
        tmr_in = 1'b1; step(3);
        chk("R4 both flags", {cap_pend, unf_pend}, 2'b11);
        chk("R4 capture zero", capture_val, 0);
        chk("R3 wrap", count_val, 16'hFFFF);
        // R7 preload ignored while running
        preload_val = 16'h1111; preload_we = 1'b1; step(2); preload_we = 1'b0;
        chk("R7 load ignored", count_val, m_cnt);
        capture_mode = 1'b0; step(1);
        hold = count_val; step(3);
        chk("R7 hold", count_val, hold);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule